// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block lives inside a DDR2 memory controller and keeps the device refreshed. A free-running interval timer adds one unit of refresh debt every `T_REFI` clock cycles. While any debt is owed and no refresh sequence is in progress, the block asks the command arbiter for a slot. Normal traffic may defer refreshes, up to eight of them. Once eight are owed, an urgent flag tells the arbiter to give the slot before the next interval ends. This keeps the gap between two refresh commands below nine intervals.

When the arbiter grants the slot, the block checks whether the banks are quiet. Quiet means every bank has been reported closed for at least `T_RP` cycles. If the banks are quiet, the refresh command goes out in the next cycle. If not, the block first issues a precharge-all, waits `T_RP` cycles and then refreshes. The busy flag covers the whole sequence and the `T_RFC` recovery window that follows the refresh. During that window the controller must not issue an activate and the block will not issue another refresh. Outside a sequence the command pins carry a NOP.

Top module: `ddr_refresh_sched`

## Requirements
- R1: During and right after reset the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with a10 low, and req, busy and urgent are all low.
- R2: The first refresh demand (req rising with no debt before) appears exactly `T_REFI` clock edges after the first edge with reset low. Each later demand arrives on a multiple of `T_REFI` edges from that same origin.
- R3: Only three command codes ever appear. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1. Refresh is cs_n=0, ras_n=0, cas_n=0, we_n=1. Precharge-all is cs_n=0, ras_n=0, cas_n=1, we_n=0 with a10=1. a10 is low in every cycle that is not a precharge-all.
- R4: A grant taken while any bank is open, or while the banks have been closed for fewer than `T_RP` cycles, puts a precharge-all on the pins in the cycle after the grant edge. The refresh follows exactly `T_RP` cycles after that precharge-all.
- R5: A grant taken after all banks have been closed for at least `T_RP` cycles puts a refresh on the pins in the cycle after the grant edge, with no precharge-all.
- R6: busy is high from the first command cycle of a sequence through `T_RFC` cycles that start with the refresh cycle. busy falls exactly `T_RFC` cycles after the refresh. req stays low while busy is high.
- R7: The owed-refresh count goes up by one per interval and down by one per refresh issued. req is high whenever the count is at least one and busy is low, and falls once the count reaches zero.
- R8: urgent is high exactly while eight refreshes are owed. It rises on an interval edge and falls with the next refresh issued.
- R9: A grant presented while req is low has no effect: no command leaves NOP and busy stays low.
- R10: The owed count saturates at eight. After more than eight intervals with no refresh, exactly eight refreshes clear the debt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open_i | input | NUM_BANKS | One bit per bank, high while that bank has an open row |
| grant_i | input | 1 | Arbiter gives the command slot to the refresh scheduler |
| req_o | output | 1 | Refresh slot requested |
| urgent_o | output | 1 | Maximum deferral reached, the slot must be given before the next interval |
| busy_o | output | 1 | Refresh sequence or recovery window in progress; activates are blocked |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10, high only for precharge-all |

## Verification
Three kinds of internal fault show up at the ports. A wrong debt count shows as a req that stays high or drops early, or as a wrong number of refreshes before req falls. It is visible within one sequence after the faulty interval, and the saturation test catches an off-by-one at eight. A wrong sequencer state or wait count moves the refresh away from its expected cycle after the grant or the precharge-all. It can also move the busy falling edge, and both are seen in the same sequence. A bad quiet-bank timer selects the wrong path, which shows as an extra or missing precharge-all in the cycle after the grant.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TRP  = 2'd1,
    ST_TRFC = 2'd2
  } seq_state_e;

  // bit order: cs_n, ras_n, cas_n, we_n, a10
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP  = 5'b01110;
  localparam dram_cmd_t CMD_REF  = 5'b00010;
  localparam dram_cmd_t CMD_PREA = 5'b00101;

endpackage

// File: rtl/refi_tick_gen.sv
module refi_tick_gen #(
  parameter int T_REFI = 3120
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = $clog2(T_REFI + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(T_REFI - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(T_REFI)); // R2

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic issue_i,
  output logic pending_o,
  output logic urgent_o
);
  localparam int DW = $clog2(MAX_DEBT + 1);

  logic [DW-1:0] debt_q;

  assign pending_o = (debt_q != '0);
  assign urgent_o  = (debt_q == DW'(MAX_DEBT));

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
    end else begin
      case ({tick_i, issue_i})
        2'b10:   if (debt_q != DW'(MAX_DEBT)) debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  AST_DEBT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    debt_q <= DW'(MAX_DEBT)); // R10
  AST_ISSUE_NEEDS_DEBT: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> debt_q != '0); // R7

endmodule

// File: rtl/bank_quiet_timer.sv
module bank_quiet_timer #(
  parameter int NUM_BANKS = 8,
  parameter int T_RP      = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 quiet_o
);
  localparam int QW = $clog2(T_RP + 1);

  logic [QW-1:0] closed_q;

  assign quiet_o = (closed_q == QW'(T_RP));

  always_ff @(posedge clk) begin
    if (rst) begin
      closed_q <= '0;
    end else if (|bank_open_i) begin
      closed_q <= '0;
    end else if (closed_q != QW'(T_RP)) begin
      closed_q <= closed_q + 1'b1;
    end
  end

  AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|bank_open_i) |=> !quiet_o); // R4

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refresh_sched_pkg::*;
#(
  parameter int T_RP  = 6,
  parameter int T_RFC = 30
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pending_i,
  input  logic      grant_i,
  input  logic      quiet_i,
  output logic      req_o,
  output logic      busy_o,
  output logic      issue_o,
  output dram_cmd_t cmd_o
);
  localparam int WMAX = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int WW   = $clog2(WMAX + 1);

  seq_state_e    state_q;
  logic [WW-1:0] wait_q;
  dram_cmd_t     cmd_q;
  logic          go;

  assign req_o   = pending_i && (state_q == ST_IDLE);
  assign go      = req_o && grant_i;
  assign issue_o = (go && quiet_i) || ((state_q == ST_TRP) && (wait_q == '0));
  assign busy_o  = (state_q != ST_IDLE);
  assign cmd_o   = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      cmd_q   <= CMD_NOP;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cmd_q <= CMD_NOP;
          if (go) begin
            if (quiet_i) begin
              state_q <= ST_TRFC;
              wait_q  <= WW'(T_RFC - 1);
              cmd_q   <= CMD_REF;
            end else begin
              state_q <= ST_TRP;
              wait_q  <= WW'(T_RP - 1);
              cmd_q   <= CMD_PREA;
            end
          end
        end
        ST_TRP: begin
          if (wait_q == '0) begin
            state_q <= ST_TRFC;
            wait_q  <= WW'(T_RFC - 1);
            cmd_q   <= CMD_REF;
          end else begin
            wait_q <= wait_q - 1'b1;
            cmd_q  <= CMD_NOP;
          end
        end
        ST_TRFC: begin
          cmd_q <= CMD_NOP;
          if (wait_q == '0) state_q <= ST_IDLE;
          else              wait_q  <= wait_q - 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          cmd_q   <= CMD_NOP;
        end
      endcase
    end
  end

  AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> cmd_q == CMD_NOP); // R3
  AST_GRANT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!req_o && !busy_o) |=> cmd_q == CMD_NOP); // R9

endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int T_REFI    = 3120,
  parameter int T_RP      = 6,
  parameter int T_RFC     = 30,
  parameter int MAX_DEBT  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 grant_i,
  output logic                 req_o,
  output logic                 urgent_o,
  output logic                 busy_o,
  output logic                 cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic                 a10_o
);
  logic      tick;
  logic      issue;
  logic      pending;
  logic      quiet;
  dram_cmd_t cmd;

  refi_tick_gen #(.T_REFI(T_REFI)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  refresh_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst(rst), .tick_i(tick), .issue_i(issue),
    .pending_o(pending), .urgent_o(urgent_o)
  );

  bank_quiet_timer #(.NUM_BANKS(NUM_BANKS), .T_RP(T_RP)) u_quiet (
    .clk(clk), .rst(rst), .bank_open_i(bank_open_i), .quiet_o(quiet)
  );

  refresh_sequencer #(.T_RP(T_RP), .T_RFC(T_RFC)) u_seq (
    .clk(clk), .rst(rst), .pending_i(pending), .grant_i(grant_i),
    .quiet_i(quiet), .req_o(req_o), .busy_o(busy_o), .issue_o(issue),
    .cmd_o(cmd)
  );

  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign a10_o   = cmd.a10;

  // spacing monitors for the command gaps
  localparam int GW = $clog2(T_RFC + 2);
  localparam int PW = $clog2(T_RP + 2);
  logic [GW-1:0] since_ref_q;
  logic [PW-1:0] since_pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ref_q <= GW'(T_RFC);
      since_pre_q <= PW'(T_RP);
    end else begin
      if (cmd == CMD_REF)                  since_ref_q <= GW'(1);
      else if (since_ref_q != GW'(T_RFC))  since_ref_q <= since_ref_q + 1'b1;
      if (cmd == CMD_PREA)                 since_pre_q <= PW'(1);
      else if (since_pre_q != PW'(T_RP))   since_pre_q <= since_pre_q + 1'b1;
    end
  end

  AST_REF_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> since_ref_q >= GW'(T_RFC)); // R6
  AST_PRE_TO_REF: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> since_pre_q >= PW'(T_RP)); // R4
  AST_URGENT_ASKS: assert property (@(posedge clk) disable iff (rst)
    (urgent_o && !busy_o) |-> req_o); // R8
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !req_o); // R6

endmodule

// File: tb/ddr_refresh_sched_bench.sv
module ddr_refresh_sched_bench;
  localparam int NB     = 4;
  localparam int T_REFI = 200;
  localparam int T_RP   = 3;
  localparam int T_RFC  = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [NB-1:0] bank_open;
  logic          grant;
  logic          req, urgent, busy, cs_n, ras_n, cas_n, we_n, a10;

  always #10 clk = ~clk;

  ddr_refresh_sched #(
    .NUM_BANKS(NB), .T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC), .MAX_DEBT(8)
  ) u_ddr_refresh_sched (
    .clk(clk), .rst(rst), .bank_open_i(bank_open), .grant_i(grant),
    .req_o(req), .urgent_o(urgent), .busy_o(busy),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .a10_o(a10)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int    kind;  // 1 precharge-all, 2 refresh
    int    at;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: every non-NOP command is popped and compared
  logic [4:0] seen;
  exp_t       cur;
  int         code;
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      seen = {cs_n, ras_n, cas_n, we_n, a10};
      if (seen != 5'b01110) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected command", int'(seen), 14);
        end else begin
          cur  = exp_q.pop_front();
          code = (cur.kind == 1) ? 5 : 2;  // R3 encodings
          chk(int'(seen) == code, "R3", "command encoding", int'(seen), code);
          chk(cyc == cur.at, cur.tag, "command cycle", cyc, cur.at);
        end
      end
    end
  end

  // driver: grant one slot and queue what must come out
  task automatic grant_one(input bit with_pre);
    int g;
    int ref_at;
    exp_t e;
    while (!req) @(negedge clk);
    g = cyc + 1;
    if (with_pre) begin
      e.kind = 1; e.at = g; e.tag = "R4"; exp_q.push_back(e);
      ref_at = g + T_RP;
      e.kind = 2; e.at = ref_at; e.tag = "R4"; exp_q.push_back(e);
    end else begin
      ref_at = g;
      e.kind = 2; e.at = ref_at; e.tag = "R5"; exp_q.push_back(e);
    end
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(busy == 1'b1, "R6", "busy at first command", int'(busy), 1);
    chk(req == 1'b0, "R6", "req while busy", int'(req), 0);
    while (busy) @(negedge clk);
    chk(cyc == ref_at + T_RFC, "R6", "busy fall cycle", cyc, ref_at + T_RFC);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  int r0;
  int u;
  int n;

  initial begin
    rst = 1'b1;
    grant = 1'b0;
    bank_open = '0;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n, a10} == 5'b01110, "R1", "reset command",
        int'({cs_n, ras_n, cas_n, we_n, a10}), 14);
    chk(!req && !busy && !urgent, "R1", "reset flags",
        int'({req, busy, urgent}), 0);
    rst = 1'b0;
    r0 = cyc;

    // first demand
    wait_cyc(r0 + T_REFI - 1);
    chk(req == 1'b0, "R2", "req before first interval", int'(req), 0);
    @(negedge clk);
    chk(req == 1'b1, "R2", "req at first interval", int'(req), 1);
    grant_one(1'b0);
    chk(req == 1'b0, "R7", "req after debt repaid", int'(req), 0);

    // grants with no request
    grant = 1'b1;
    repeat (5) @(negedge clk);
    grant = 1'b0;
    chk(busy == 1'b0, "R9", "busy after stray grant", int'(busy), 0);
    chk(req == 1'b0, "R9", "req after stray grant", int'(req), 0);

    // second interval, bank open
    wait_cyc(r0 + 2 * T_REFI - 1);
    chk(req == 1'b0, "R2", "req before second interval", int'(req), 0);
    bank_open = 4'b0010;
    @(negedge clk);
    chk(req == 1'b1, "R2", "req at second interval", int'(req), 1);
    grant_one(1'b1);
    bank_open = '0;

    // third interval, banks closed too recently
    wait_cyc(r0 + 3 * T_REFI - 1);
    bank_open = 4'b1000;
    @(negedge clk);
    bank_open = '0;
    grant_one(1'b1);

    // let debt build up to the limit
    while (!urgent) @(negedge clk);
    u = cyc;
    chk(u == r0 + 11 * T_REFI, "R8", "urgent rise cycle", u, r0 + 11 * T_REFI);
    wait_cyc(r0 + 12 * T_REFI + 1);
    chk(urgent == 1'b1, "R10", "urgent after extra interval", int'(urgent), 1);
    chk(req == 1'b1, "R7", "req with debt owed", int'(req), 1);

    n = 0;
    while (req) begin
      grant_one(1'b0);
      n++;
      if (n == 1) chk(urgent == 1'b0, "R8", "urgent after one refresh", int'(urgent), 0);
    end
    chk(n == 8, "R10", "refreshes to clear saturated debt", n, 8);
    chk(exp_q.size() == 0, "R3", "expected commands left over", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule